// File: doc/BRIEF.md
# Pulse-Input Speed Capture Unit

This block watches an incoming pulse stream and turns it into a signed rate in hertz. It also keeps a signed 32-bit running total of the pulses it has counted. A mode input picks the input type. In single-line mode, rising edges on line A are counted upward. In quadrature mode, lines A and B are decoded as an A/B pair at four counts per cycle, and the phase order decides whether each count is added or subtracted.

The rate is not measured over a fixed time gate. A window closes after N counted edges. The block counts reference ticks from the edge that opened the window to the edge that closes it, then divides N times the tick rate by that tick count in a serial divider. The result is the rate in counted edges per second. It is limited to plus or minus 10000 and published together with a one-cycle valid strobe. The closing edge opens the next window.

N is written into a holding register and only takes effect on a separate apply strobe. It is limited to a range that depends on the mode. If the input stops, the speed drops to zero after a timeout.

Top module: `pulse_speed_capture`

## Requirements
- R1: In single-line mode (modeQuad = 0), every rising edge of pulseA adds one to pulseTotal. Activity on pulseB has no effect in this mode.
- R2: In quadrature mode (modeQuad = 1), the pair {pulseA, pulseB} steps forward through 00, 10, 11, 01, 00, with A leading. Each forward step adds one to pulseTotal and each backward step subtracts one.
- R3: In quadrature mode, a transition in which both lines change together is not counted and sets quadError. quadError then stays high until reset. quadError never rises in single-line mode.
- R4: Each measurement spans N counted edge intervals. The reported speed is floor(N × TICK_HZ / elapsed ticks), which equals floor(TICK_HZ / edge spacing) for a steady input. It is presented on speedHz together with a one-cycle sampleValid pulse. speedHz changes only on sampleValid or when it is forced to zero.
- R5: A window of backward quadrature steps reports a negative speed. A counted edge in the direction opposite to the open window restarts the window at that edge.
- R6: The magnitude of speedHz is limited to SPEED_MAX, which is 10000 by default.
- R7: The effective N is the applied setting limited to 1..N_MAX in single-line mode and to 2..N_MAX in quadrature mode. Values outside the range, including zero and negative values, take the nearest bound.
- R8: sampleWr stores sampleSet in a holding register without affecting measurements. sampleApply copies the held value into the active setting.
- R9: If no counted edge arrives for TIMEOUT_TICKS ticks, speedHz becomes zero and the open window is abandoned without a sampleValid pulse.
- R10: Synchronous reset clears pulseTotal, speedHz, quadError and the window state, and sets both the held and the active N to N_RESET (4 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the reference tick is clk divided by TICK_DIV |
| rst | input | 1 | Synchronous reset, active high |
| modeQuad | input | 1 | 0 = single-line counting, 1 = A/B quadrature |
| pulseA | input | 1 | Asynchronous pulse line A |
| pulseB | input | 1 | Asynchronous pulse line B |
| sampleWr | input | 1 | Store sampleSet into the holding register |
| sampleSet | input | 16 | Signed requested edges per measurement |
| sampleApply | input | 1 | Make the held setting active |
| speedHz | output | SPEED_W | Signed latest speed in counted edges per second |
| pulseTotal | output | 32 | Signed running count of counted edges |
| sampleValid | output | 1 | One-cycle strobe marking a new speedHz value |
| quadError | output | 1 | Sticky flag for a quadrature transition in which both lines changed |

## Verification
Some properties are checked on every cycle by the checker. These are the speed bound, the single-cycle width of sampleValid, the rule that speedHz moves only with sampleValid or to zero, the rule that pulseTotal moves by at most one per cycle and never downward in single-line mode, and the stickiness of quadError. Other behaviour needs the bench's scenarios, because it depends on the stimulus history. This covers the measured values for given edge spacings, the number of measurements implied by the effective N, the clamping of N, the need for an apply strobe, restart on a direction change, and the timeout to zero.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // strobes from the window control to the datapath
  typedef struct packed {
    logic tick;       // reference tick of this cycle
    logic winStart;   // reset the elapsed-tick counter
    logic divStart;   // launch a division for the window just closed
    logic divDown;    // sign of the window just closed
    logic forceZero;  // idle timeout reached
  } spcCtrl_t;

endpackage

// File: rtl/spc_decoder.sv
module spc_decoder (
  input  logic clk,
  input  logic rst,
  input  logic modeQuad,
  input  logic inA,
  input  logic inB,
  output logic stepValid,
  output logic stepDown,
  output logic quadErr
);

  logic [1:0] syncA, syncB;
  logic       prevA, prevB;
  logic       curA, curB, chgA, chgB;
  logic       errQ;

  assign curA = syncA[1];
  assign curB = syncB[1];
  assign chgA = curA ^ prevA;
  assign chgB = curB ^ prevB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
      prevA <= 1'b0;
      prevB <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      syncA <= {syncA[0], inA};
      syncB <= {syncB[0], inB};
      prevA <= curA;
      prevB <= curB;
      if (modeQuad && chgA && chgB) errQ <= 1'b1;
    end
  end

  always_comb begin
    if (modeQuad) begin
      // exactly one line moved: a legal quadrature step
      stepValid = chgA ^ chgB;
      // A moving: forward when the new A differs from B
      // B moving: forward when the new B equals A
      stepDown  = chgA ? ~(curA ^ prevB) : (curB ^ prevA);
    end else begin
      stepValid = curA & ~prevA;
      stepDown  = 1'b0;
    end
  end

  assign quadErr = errQ;

endmodule

// File: rtl/spc_control.sv
module spc_control
  import spc_pkg::*;
#(
  parameter int TICK_DIV      = 1,
  parameter int TIMEOUT_TICKS = 1_000_000,
  parameter int NW            = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stepValid,
  input  logic          stepDown,
  input  logic [NW-1:0] effN,
  input  logic          divBusy,
  output spcCtrl_t      ctrl
);

  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int IW = $clog2(TIMEOUT_TICKS + 1);

  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (rst) divCnt <= '0;
        else if (divCnt == DW'(TICK_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DW'(TICK_DIV - 1));
    end
  endgenerate

  logic          winActive, winDown;
  logic [NW-1:0] edgeCnt;
  logic [IW-1:0] idleCnt;
  logic          restart, closeWin, timeoutHit;

  always_comb begin
    restart    = stepValid && (!winActive || (stepDown != winDown));
    closeWin   = stepValid && !restart && ((edgeCnt + 1'b1) == effN);
    timeoutHit = !stepValid && tick && (idleCnt == IW'(TIMEOUT_TICKS - 1));

    ctrl.tick      = tick;
    ctrl.winStart  = restart || closeWin;
    ctrl.divStart  = closeWin && !divBusy;
    ctrl.divDown   = winDown;
    ctrl.forceZero = timeoutHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winActive <= 1'b0;
      winDown   <= 1'b0;
      edgeCnt   <= '0;
      idleCnt   <= '0;
    end else if (stepValid) begin
      idleCnt <= '0;
      if (restart) begin
        winActive <= 1'b1;
        winDown   <= stepDown;
        edgeCnt   <= '0;
      end else if (closeWin) begin
        edgeCnt <= '0;
      end else begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end else if (tick && (idleCnt != IW'(TIMEOUT_TICKS))) begin
      idleCnt <= idleCnt + 1'b1;
      if (timeoutHit) winActive <= 1'b0;
    end
  end

endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int TICK_HZ   = 1_000_000,
  parameter int N_MAX     = 100,
  parameter int N_RESET   = 4,
  parameter int SPEED_MAX = 10000,
  parameter int SPEED_W   = 16,
  parameter int NW        = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      modeQuad,
  input  logic                      sampleWr,
  input  logic [15:0]               sampleSet,
  input  logic                      sampleApply,
  input  logic                      stepValid,
  input  logic                      stepDown,
  input  spcCtrl_t                  ctrl,
  output logic [NW-1:0]             effN,
  output logic                      divBusy,
  output logic signed [SPEED_W-1:0] speed,
  output logic signed [31:0]        total,
  output logic                      sampleValid
);

  localparam logic signed [15:0] N_HI   = 16'(N_MAX);
  localparam logic signed [15:0] N_INIT = 16'(N_RESET);
  localparam logic [31:0]        TICK_C = 32'(TICK_HZ);
  localparam logic [31:0]        SMAX_C = 32'(SPEED_MAX);

  // sample-count setting: holding copy and active copy
  logic signed [15:0] shadowN, activeN, clampN, loN;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowN <= N_INIT;
      activeN <= N_INIT;
    end else begin
      if (sampleWr)    shadowN <= $signed(sampleSet);
      if (sampleApply) activeN <= shadowN;
    end
  end

  always_comb begin
    loN = modeQuad ? 16'sd2 : 16'sd1;
    if (activeN < loN)       clampN = loN;
    else if (activeN > N_HI) clampN = N_HI;
    else                     clampN = activeN;
  end

  assign effN = NW'(clampN);

  // elapsed ticks inside the open window, saturating
  logic [31:0] elapsed, divisorNow;

  always_ff @(posedge clk) begin
    if (rst)                                 elapsed <= '0;
    else if (ctrl.winStart)                  elapsed <= '0;
    else if (ctrl.tick && (elapsed != '1))   elapsed <= elapsed + 1'b1;
  end

  assign divisorNow = (elapsed == '1) ? elapsed : elapsed + {31'b0, ctrl.tick};

  // running pulse total
  always_ff @(posedge clk) begin
    if (rst)            total <= '0;
    else if (stepValid) total <= stepDown ? total - 32'sd1 : total + 32'sd1;
  end

  // serial restoring divider
  logic [31:0] rem, quo, dvsr, prod;
  logic [32:0] remShift, remSub;
  logic [5:0]  bitCnt;
  logic        busy, negQ, fits;
  logic [SPEED_W-1:0] mag;

  assign prod     = 32'(effN) * TICK_C;
  assign remShift = {rem, quo[31]};
  assign remSub   = remShift - {1'b0, dvsr};
  assign fits     = ~remSub[32];
  assign mag      = (quo > SMAX_C) ? SPEED_W'(SPEED_MAX) : quo[SPEED_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      negQ        <= 1'b0;
      bitCnt      <= '0;
      rem         <= '0;
      quo         <= '0;
      dvsr        <= '0;
      speed       <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (ctrl.forceZero) begin
        busy  <= 1'b0;
        speed <= '0;
      end else if (ctrl.divStart) begin
        busy   <= 1'b1;
        negQ   <= ctrl.divDown;
        bitCnt <= '0;
        rem    <= '0;
        quo    <= prod;
        dvsr   <= divisorNow;
      end else if (busy) begin
        if (bitCnt == 6'd32) begin
          busy        <= 1'b0;
          sampleValid <= 1'b1;
          speed       <= negQ ? -$signed(mag) : $signed(mag);
        end else begin
          rem    <= fits ? remSub[31:0] : remShift[31:0];
          quo    <= {quo[30:0], fits};
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign divBusy = busy;

endmodule

// File: rtl/pulse_speed_capture.sv
module pulse_speed_capture
  import spc_pkg::*;
#(
  parameter int TICK_HZ       = 1_000_000,
  parameter int TICK_DIV      = 1,
  parameter int TIMEOUT_TICKS = 1_000_000,
  parameter int N_MAX         = 100,
  parameter int N_RESET       = 4,
  parameter int SPEED_MAX     = 10000,
  parameter int SPEED_W       = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      modeQuad,
  input  logic                      pulseA,
  input  logic                      pulseB,
  input  logic                      sampleWr,
  input  logic [15:0]               sampleSet,
  input  logic                      sampleApply,
  output logic signed [SPEED_W-1:0] speedHz,
  output logic signed [31:0]        pulseTotal,
  output logic                      sampleValid,
  output logic                      quadError
);

  localparam int NW = $clog2(N_MAX + 1);

  logic          stepValid, stepDown, divBusy;
  logic [NW-1:0] effN;
  spcCtrl_t      ctrl;

  spc_decoder u_dec (
    .clk       (clk),
    .rst       (rst),
    .modeQuad  (modeQuad),
    .inA       (pulseA),
    .inB       (pulseB),
    .stepValid (stepValid),
    .stepDown  (stepDown),
    .quadErr   (quadError)
  );

  spc_control #(
    .TICK_DIV      (TICK_DIV),
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .NW            (NW)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .stepValid (stepValid),
    .stepDown  (stepDown),
    .effN      (effN),
    .divBusy   (divBusy),
    .ctrl      (ctrl)
  );

  spc_datapath #(
    .TICK_HZ   (TICK_HZ),
    .N_MAX     (N_MAX),
    .N_RESET   (N_RESET),
    .SPEED_MAX (SPEED_MAX),
    .SPEED_W   (SPEED_W),
    .NW        (NW)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .modeQuad    (modeQuad),
    .sampleWr    (sampleWr),
    .sampleSet   (sampleSet),
    .sampleApply (sampleApply),
    .stepValid   (stepValid),
    .stepDown    (stepDown),
    .ctrl        (ctrl),
    .effN        (effN),
    .divBusy     (divBusy),
    .speed       (speedHz),
    .total       (pulseTotal),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int SPEED_MAX = 10000,
  parameter int SPEED_W   = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      modeQuad,
  input logic signed [SPEED_W-1:0] speedHz,
  input logic signed [31:0]        pulseTotal,
  input logic                      sampleValid,
  input logic                      quadError
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R6
  speed_range_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (int'(speedHz) <= SPEED_MAX) && (int'(speedHz) >= -SPEED_MAX));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    sampleValid |=> !sampleValid);

  // R4 and R9
  speed_change_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(speedHz) |-> (sampleValid || (speedHz == '0)));

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    quadError |=> quadError);

  // R3
  err_single_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!modeQuad && !quadError) |=> !quadError);

  // R2
  total_step_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(pulseTotal) |->
      ((pulseTotal == $past(pulseTotal) + 32'sd1) || (pulseTotal == $past(pulseTotal) - 32'sd1)));

  // R1
  single_up_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !modeQuad |=> ((pulseTotal == $past(pulseTotal)) || (pulseTotal == $past(pulseTotal) + 32'sd1)));

endmodule

bind pulse_speed_capture spc_checker #(
  .SPEED_MAX (SPEED_MAX),
  .SPEED_W   (SPEED_W)
) u_chk (.*);

// File: tb/test_pulse_speed_capture.sv
module test_pulse_speed_capture;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_HZ    = 1_000_000;
  localparam int TIMEOUT    = 3000;
  localparam int SMAX       = 10000;

  logic clk = 1'b0, rst = 1'b1, modeQuad = 1'b0;
  logic pulseA = 1'b0, pulseB = 1'b0, sampleWr = 1'b0, sampleApply = 1'b0;
  logic [15:0] sampleSet = '0;
  logic signed [15:0] speedHz;
  logic signed [31:0] pulseTotal;
  logic sampleValid, quadError;

  int total = 0, bad = 0, expTotal = 0, qState = 0, popVal;
  int expQ[$];
  string tagQ[$];
  string popTag;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_speed_capture #(.TIMEOUT_TICKS(TIMEOUT)) i_pulse_speed_capture (
    .clk(clk), .rst(rst), .modeQuad(modeQuad), .pulseA(pulseA), .pulseB(pulseB),
    .sampleWr(sampleWr), .sampleSet(sampleSet), .sampleApply(sampleApply),
    .speedHz(speedHz), .pulseTotal(pulseTotal), .sampleValid(sampleValid),
    .quadError(quadError)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per published measurement
  always @(negedge clk) begin
    if (!rst && sampleValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R4 unexpected sample actual=%0d expected=none", speedHz);
      end else begin
        popVal = expQ.pop_front();
        popTag = tagQ.pop_front();
        check(popTag, int'(speedHz), popVal);
      end
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setN(int v, bit apply);
    @(negedge clk); sampleSet = 16'(v); sampleWr = 1'b1;
    @(negedge clk); sampleWr = 1'b0;
    if (apply) begin
      sampleApply = 1'b1; @(negedge clk); sampleApply = 1'b0;
    end
  endtask

  function automatic int expSpeed(int period, bit neg);
    int s = TICK_HZ / period;
    if (s > SMAX) s = SMAX;
    return neg ? -s : s;
  endfunction

  task automatic pushExp(int n, int v, string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(v);
      tagQ.push_back(tag);
    end
  endtask

  task automatic runSingle(int period, int count, int nEff, bit wiggleB, string tag);
    pushExp((count - 1) / nEff, expSpeed(period, 1'b0), tag);
    for (int i = 0; i < count; i++) begin
      pulseA = 1'b1; if (wiggleB) pulseB = ~pulseB;
      waitCyc(period / 2);
      pulseA = 1'b0; if (wiggleB) pulseB = ~pulseB;
      waitCyc(period - period / 2);
    end
    pulseB = 1'b0;
    expTotal += count;
  endtask

  function automatic logic [1:0] abOf(int idx);
    case (idx)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic runQuad(int period, int count, int nEff, bit down, string tag);
    pushExp((count - 1) / nEff, expSpeed(period, down), tag);
    for (int i = 0; i < count; i++) begin
      qState = down ? (qState + 3) % 4 : (qState + 1) % 4;
      {pulseA, pulseB} = abOf(qState);
      waitCyc(period);
    end
    expTotal += down ? -count : count;
  endtask

  task automatic idleCheck(string tag);
    waitCyc(TIMEOUT + 60);
    check({"R9 speed zero after idle, ", tag}, int'(speedHz), 0);
    check({"R4 all measurements seen, ", tag}, expQ.size(), 0);
    check({"R1 total, ", tag}, int'(pulseTotal), expTotal);
  endtask

  initial begin
    waitCyc(3);
    rst = 1'b0;
    waitCyc(1);
    // R10 reset state
    check("R10 reset speed", int'(speedHz), 0);
    check("R10 reset total", int'(pulseTotal), 0);
    check("R10 reset valid", int'(sampleValid), 0);
    check("R10 reset error", int'(quadError), 0);

    // R1 R4: single-line, B wiggling, N=4 from reset, 200-cycle spacing
    runSingle(200, 9, 4, 1'b1, "R4 single 5000");
    idleCheck("R1 single");

    // R7: zero clamps to 1 in single-line mode
    setN(0, 1'b1);
    runSingle(1000, 4, 1, 1'b0, "R7 clamp low");
    idleCheck("R7 low");

    // R8: write without apply leaves N=1
    setN(3, 1'b0);
    runSingle(300, 5, 1, 1'b0, "R8 held not active");
    idleCheck("R8 held");
    @(negedge clk); sampleApply = 1'b1; @(negedge clk); sampleApply = 1'b0;
    runSingle(300, 7, 3, 1'b0, "R8 applied");
    idleCheck("R8 applied");

    // R6: faster than the limit
    runSingle(50, 7, 3, 1'b0, "R6 positive limit");
    idleCheck("R6 pos");

    // R7: above range clamps to 100
    setN(200, 1'b1);
    runSingle(50, 102, 100, 1'b0, "R7 clamp high");
    idleCheck("R7 high");

    // R2 R7: quadrature, setting 1 clamps to 2
    modeQuad = 1'b1;
    waitCyc(5);
    setN(1, 1'b1);
    runQuad(125, 9, 2, 1'b0, "R2 quad forward, R7 quad min");
    idleCheck("R2 fwd");

    // R5: backward gives negative speed
    runQuad(125, 5, 2, 1'b1, "R5 quad backward");
    idleCheck("R5 back");

    // R5: reversal restarts the window
    runQuad(125, 5, 2, 1'b0, "R5 turn forward part");
    runQuad(125, 5, 2, 1'b1, "R5 turn backward part");
    idleCheck("R5 turn");

    // R6: negative limit
    runQuad(50, 5, 2, 1'b1, "R6 negative limit");
    idleCheck("R6 neg");

    // R3: both lines change together
    check("R3 error clear before", int'(quadError), 0);
    qState = (qState + 2) % 4;
    {pulseA, pulseB} = abOf(qState);
    waitCyc(10);
    check("R3 double change not counted", int'(pulseTotal), expTotal);
    check("R3 error set", int'(quadError), 1);
    qState = (qState + 1) % 4;
    {pulseA, pulseB} = abOf(qState);
    expTotal += 1;
    waitCyc(10);
    check("R3 legal step after error", int'(pulseTotal), expTotal);
    check("R3 error sticky", int'(quadError), 1);
    idleCheck("R3");

    // R10: reset clears state and restores N
    rst = 1'b1;
    pulseA = 1'b0; pulseB = 1'b0; modeQuad = 1'b0; qState = 0;
    waitCyc(4);
    rst = 1'b0;
    waitCyc(1);
    expTotal = 0;
    check("R10 total cleared", int'(pulseTotal), 0);
    check("R10 error cleared", int'(quadError), 0);
    check("R10 speed cleared", int'(speedHz), 0);
    runSingle(200, 5, 4, 1'b0, "R10 N restored");
    idleCheck("R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule